// File: doc/BRIEF.md
# Dual-Section Latched Bidirectional Bus Transceiver

This block joins two bidirectional byte-wide buses, A and B, in two independent sections. Each section has a storage latch for the A-to-B direction and another for the B-to-A direction. Each direction is steered by three active-low controls:

- a direction enable, which gates both loading of the latch and driving of the outputs;
- a latch enable, which opens the latch so that it follows its source;
- an output enable, which turns the destination drivers on.

Each pad is modelled as a data input, an external-driver-present flag, a data output and a drive-enable flag. A keeper on every input bit holds the last externally driven level when nothing drives the pin.

The whole block runs on one system clock. Control edges are found by comparing each control with its value registered on the previous clock. On a capture edge, the latch stores the source data sampled in that same cycle. While a latch is loading, whether because it is open or because a capture edge is active, the path shows the incoming value. Otherwise it shows the stored value. Data is never inverted.

A direction can load its latch while its outputs stay off. A conflict flag per section reports when both directions drive their pins at the same time.

Top module: `bus_latch_xcvr`

## Requirements
- R1: In a section, the B drive-enable is 1 exactly when the A-to-B direction enable and output enable are both 0, and the A drive-enable is 1 exactly when the B-to-A pair are both 0; otherwise the port is undriven.
- R2: With the direction enable and latch enable of a path both 0, the destination data equals the effective source value in the same cycle, not inverted.
- R3: A 0-to-1 change of the latch enable while the direction enable is 0 stores the source value of that cycle, and the path then shows it.
- R4: A 0-to-1 change of the direction enable while the latch enable is 0 also stores the source value of that cycle.
- R5: With the latch enable at 1 and the direction enable at 0, and no capture edge active, the stored value and the destination data do not change whatever the source does.
- R6: A value loaded while the output enable is 1 is shown once the outputs are enabled, and no edge-free cycle with the direction enable at 1 alters it.
- R7: The B-to-A path behaves as the mirror of the A-to-B path, and each section's controls affect only that section's pins.
- R8: When an input bit's driver-present flag is 0, its effective value is the last value seen while it was driven.
- R9: A section's conflict flag is 1 exactly when its A and B drive-enables are both 1.
- R10: A synchronous active-high reset clears every latch and every keeper to zero, and leaves both directions without a pending edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ab_en_n | input | SECTIONS | A-to-B direction enable per section, active low |
| ab_le_n | input | SECTIONS | A-to-B latch enable per section, active low |
| ab_oe_n | input | SECTIONS | A-to-B output enable per section, active low |
| ba_en_n | input | SECTIONS | B-to-A direction enable per section, active low |
| ba_le_n | input | SECTIONS | B-to-A latch enable per section, active low |
| ba_oe_n | input | SECTIONS | B-to-A output enable per section, active low |
| a_pin_i | input | SECTIONS*WIDTH | Level on the A pins, section s at bits s*WIDTH upward |
| a_pin_drv | input | SECTIONS*WIDTH | 1 where an external driver is present on an A pin |
| b_pin_i | input | SECTIONS*WIDTH | Level on the B pins |
| b_pin_drv | input | SECTIONS*WIDTH | 1 where an external driver is present on a B pin |
| a_pin_o | output | SECTIONS*WIDTH | Data driven onto the A pins by the B-to-A path |
| a_pin_oe | output | SECTIONS | A drivers on, per section |
| b_pin_o | output | SECTIONS*WIDTH | Data driven onto the B pins by the A-to-B path |
| b_pin_oe | output | SECTIONS | B drivers on, per section |
| conflict_o | output | SECTIONS | Both directions of a section driving at once |

## Verification
Two functions can fall in the same cycle: loading a latch and driving its outputs, and driving both directions of one section.

The stimulus table provokes the first case twice:
- a load by a direction-enable rise while the outputs are off, which is later revealed under a hold with the outputs on;
- a latch-enable rise that captures while the path is shown.

It provokes the second case by enabling both directions. One of those steps reads the B side through its keeper rather than a live driver.

Each step is judged after the clock edge on both drive-enables, on both data words where they are driven, and on the conflict flag.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int unsigned DEF_SECTIONS = 2;
  localparam int unsigned DEF_WIDTH    = 8;

  // A path loads when each of its two gating controls is either low now
  // or has just risen in this cycle.
  function automatic logic path_loads(input logic en_n, input logic en_rise,
                                      input logic le_n, input logic le_rise);
    return (!en_n || en_rise) && (!le_n || le_rise);
  endfunction

  // A path drives its destination only with both direction and output enable low.
  function automatic logic path_drives(input logic en_n, input logic oe_n);
    return !en_n && !oe_n;
  endfunction

  // Rising edge of an active-low control against its registered copy.
  function automatic logic ctl_rise(input logic now_n, input logic prev_n);
    return now_n && !prev_n;
  endfunction

endpackage

// File: rtl/xcvr_bus_keeper.sv
module xcvr_bus_keeper #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] drv_i,
  output logic [WIDTH-1:0] eff_o
);

  logic [WIDTH-1:0] keep_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign eff_o[i] = drv_i[i] ? pin_i[i] : keep_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) keep_q <= '0;
    else     keep_q <= eff_o;
  end

endmodule

// File: rtl/xcvr_latch_path.sv
module xcvr_latch_path
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] src_i,
  input  logic             en_n_i,
  input  logic             le_n_i,
  input  logic             oe_n_i,
  output logic [WIDTH-1:0] dat_o,
  output logic             drive_o,
  output logic             load_o
);

  logic             en_prev_q;
  logic             le_prev_q;
  logic [WIDTH-1:0] store_q;
  logic             en_rise;
  logic             le_rise;

  assign en_rise = ctl_rise(en_n_i, en_prev_q);
  assign le_rise = ctl_rise(le_n_i, le_prev_q);
  assign load_o  = path_loads(en_n_i, en_rise, le_n_i, le_rise);
  assign drive_o = path_drives(en_n_i, oe_n_i);
  assign dat_o   = load_o ? src_i : store_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_prev_q <= 1'b1;
      le_prev_q <= 1'b1;
      store_q   <= '0;
    end else begin
      en_prev_q <= en_n_i;
      le_prev_q <= le_n_i;
      if (load_o) store_q <= src_i;
    end
  end

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ab_en_n,
  input  logic             ab_le_n,
  input  logic             ab_oe_n,
  input  logic             ba_en_n,
  input  logic             ba_le_n,
  input  logic             ba_oe_n,
  input  logic [WIDTH-1:0] a_pin_i,
  input  logic [WIDTH-1:0] a_pin_drv,
  input  logic [WIDTH-1:0] b_pin_i,
  input  logic [WIDTH-1:0] b_pin_drv,
  output logic [WIDTH-1:0] a_pin_o,
  output logic             a_pin_oe,
  output logic [WIDTH-1:0] b_pin_o,
  output logic             b_pin_oe,
  output logic [WIDTH-1:0] a_eff,
  output logic [WIDTH-1:0] b_eff,
  output logic             ab_load,
  output logic             ba_load,
  output logic             conflict_o
);

  xcvr_bus_keeper #(.WIDTH(WIDTH)) u_keep_a (
    .clk(clk), .rst(rst), .pin_i(a_pin_i), .drv_i(a_pin_drv), .eff_o(a_eff)
  );

  xcvr_bus_keeper #(.WIDTH(WIDTH)) u_keep_b (
    .clk(clk), .rst(rst), .pin_i(b_pin_i), .drv_i(b_pin_drv), .eff_o(b_eff)
  );

  xcvr_latch_path #(.WIDTH(WIDTH)) u_ab (
    .clk(clk), .rst(rst), .src_i(a_eff),
    .en_n_i(ab_en_n), .le_n_i(ab_le_n), .oe_n_i(ab_oe_n),
    .dat_o(b_pin_o), .drive_o(b_pin_oe), .load_o(ab_load)
  );

  xcvr_latch_path #(.WIDTH(WIDTH)) u_ba (
    .clk(clk), .rst(rst), .src_i(b_eff),
    .en_n_i(ba_en_n), .le_n_i(ba_le_n), .oe_n_i(ba_oe_n),
    .dat_o(a_pin_o), .drive_o(a_pin_oe), .load_o(ba_load)
  );

  assign conflict_o = a_pin_oe && b_pin_oe;

endmodule

// File: rtl/bus_latch_xcvr.sv
module bus_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned SECTIONS = DEF_SECTIONS,
  parameter int unsigned WIDTH    = DEF_WIDTH
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [SECTIONS-1:0]          ab_en_n,
  input  logic [SECTIONS-1:0]          ab_le_n,
  input  logic [SECTIONS-1:0]          ab_oe_n,
  input  logic [SECTIONS-1:0]          ba_en_n,
  input  logic [SECTIONS-1:0]          ba_le_n,
  input  logic [SECTIONS-1:0]          ba_oe_n,
  input  logic [SECTIONS*WIDTH-1:0]    a_pin_i,
  input  logic [SECTIONS*WIDTH-1:0]    a_pin_drv,
  input  logic [SECTIONS*WIDTH-1:0]    b_pin_i,
  input  logic [SECTIONS*WIDTH-1:0]    b_pin_drv,
  output logic [SECTIONS*WIDTH-1:0]    a_pin_o,
  output logic [SECTIONS-1:0]          a_pin_oe,
  output logic [SECTIONS*WIDTH-1:0]    b_pin_o,
  output logic [SECTIONS-1:0]          b_pin_oe,
  output logic [SECTIONS-1:0]          conflict_o
);

  localparam int unsigned BUSW = SECTIONS * WIDTH;

  // Internal events brought out by name for the bound checker.
  logic [BUSW-1:0]     a_eff;
  logic [BUSW-1:0]     b_eff;
  logic [SECTIONS-1:0] ab_load;
  logic [SECTIONS-1:0] ba_load;

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    xcvr_section #(.WIDTH(WIDTH)) u_sec (
      .clk       (clk),
      .rst       (rst),
      .ab_en_n   (ab_en_n[s]),
      .ab_le_n   (ab_le_n[s]),
      .ab_oe_n   (ab_oe_n[s]),
      .ba_en_n   (ba_en_n[s]),
      .ba_le_n   (ba_le_n[s]),
      .ba_oe_n   (ba_oe_n[s]),
      .a_pin_i   (a_pin_i[s*WIDTH +: WIDTH]),
      .a_pin_drv (a_pin_drv[s*WIDTH +: WIDTH]),
      .b_pin_i   (b_pin_i[s*WIDTH +: WIDTH]),
      .b_pin_drv (b_pin_drv[s*WIDTH +: WIDTH]),
      .a_pin_o   (a_pin_o[s*WIDTH +: WIDTH]),
      .a_pin_oe  (a_pin_oe[s]),
      .b_pin_o   (b_pin_o[s*WIDTH +: WIDTH]),
      .b_pin_oe  (b_pin_oe[s]),
      .a_eff     (a_eff[s*WIDTH +: WIDTH]),
      .b_eff     (b_eff[s*WIDTH +: WIDTH]),
      .ab_load   (ab_load[s]),
      .ba_load   (ba_load[s]),
      .conflict_o(conflict_o[s])
    );
  end

endmodule

// File: rtl/bus_latch_xcvr_chk.sv
module bus_latch_xcvr_chk #(
  parameter int unsigned SECTIONS = 2,
  parameter int unsigned WIDTH    = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [SECTIONS-1:0]       ab_en_n,
  input logic [SECTIONS-1:0]       ab_le_n,
  input logic [SECTIONS-1:0]       ab_oe_n,
  input logic [SECTIONS-1:0]       ba_en_n,
  input logic [SECTIONS-1:0]       ba_le_n,
  input logic [SECTIONS-1:0]       ba_oe_n,
  input logic [SECTIONS*WIDTH-1:0] a_pin_drv,
  input logic [SECTIONS*WIDTH-1:0] b_pin_drv,
  input logic [SECTIONS*WIDTH-1:0] a_pin_o,
  input logic [SECTIONS-1:0]       a_pin_oe,
  input logic [SECTIONS*WIDTH-1:0] b_pin_o,
  input logic [SECTIONS-1:0]       b_pin_oe,
  input logic [SECTIONS-1:0]       conflict_o,
  input logic [SECTIONS*WIDTH-1:0] a_eff,
  input logic [SECTIONS*WIDTH-1:0] b_eff
);

  // Set once a clock edge outside reset has passed, so $past never
  // reaches into the reset period.
  logic pv;
  always_ff @(posedge clk) pv <= !rst;

  for (genvar s = 0; s < SECTIONS; s++) begin : g_s
    AST_AB_OFF: assert property (@(posedge clk) disable iff (rst)
      (ab_en_n[s] || ab_oe_n[s]) |-> !b_pin_oe[s]); // R1
    AST_AB_ON: assert property (@(posedge clk) disable iff (rst)
      (!ab_en_n[s] && !ab_oe_n[s]) |-> b_pin_oe[s]); // R1
    AST_BA_OFF: assert property (@(posedge clk) disable iff (rst)
      (ba_en_n[s] || ba_oe_n[s]) |-> !a_pin_oe[s]); // R7
    AST_AB_TRANSP: assert property (@(posedge clk) disable iff (rst)
      (!ab_en_n[s] && !ab_le_n[s]) |-> b_pin_o[s*WIDTH +: WIDTH] == a_eff[s*WIDTH +: WIDTH]); // R2
    AST_BA_TRANSP: assert property (@(posedge clk) disable iff (rst)
      (!ba_en_n[s] && !ba_le_n[s]) |-> a_pin_o[s*WIDTH +: WIDTH] == b_eff[s*WIDTH +: WIDTH]); // R7
    AST_LE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      (pv && $rose(ab_le_n[s]) && !ab_en_n[s]) |=>
      (ab_en_n[s] || !ab_le_n[s] || b_pin_o[s*WIDTH +: WIDTH] == $past(a_eff[s*WIDTH +: WIDTH]))); // R3
    AST_EN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      (pv && $rose(ab_en_n[s]) && !ab_le_n[s]) |=>
      (ab_en_n[s] || !ab_le_n[s] || b_pin_o[s*WIDTH +: WIDTH] == $past(a_eff[s*WIDTH +: WIDTH]))); // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      (pv && !ab_en_n[s] && ab_le_n[s] && $past(ab_le_n[s]) && !$past(ab_en_n[s])) |->
      $stable(b_pin_o[s*WIDTH +: WIDTH])); // R5
    AST_CONFLICT_SET: assert property (@(posedge clk) disable iff (rst)
      (a_pin_oe[s] && b_pin_oe[s]) |-> conflict_o[s]); // R9
    AST_CONFLICT_REAL: assert property (@(posedge clk) disable iff (rst)
      conflict_o[s] |-> (a_pin_oe[s] && b_pin_oe[s])); // R9
  end

  for (genvar i = 0; i < SECTIONS*WIDTH; i++) begin : g_b
    AST_KEEP_A: assert property (@(posedge clk) disable iff (rst)
      (pv && !a_pin_drv[i] && !$past(a_pin_drv[i])) |-> $stable(a_eff[i])); // R8
    AST_KEEP_B: assert property (@(posedge clk) disable iff (rst)
      (pv && !b_pin_drv[i] && !$past(b_pin_drv[i])) |-> $stable(b_eff[i])); // R8
    AST_KEEP_CLEAR: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !a_pin_drv[i]) |-> !a_eff[i]); // R10
  end

endmodule

bind bus_latch_xcvr bus_latch_xcvr_chk #(.SECTIONS(SECTIONS), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst),
  .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
  .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
  .a_pin_drv(a_pin_drv), .b_pin_drv(b_pin_drv),
  .a_pin_o(a_pin_o), .a_pin_oe(a_pin_oe),
  .b_pin_o(b_pin_o), .b_pin_oe(b_pin_oe),
  .conflict_o(conflict_o), .a_eff(a_eff), .b_eff(b_eff)
);

// File: tb/sim_bus_latch_xcvr.sv
module sim_bus_latch_xcvr;

  localparam int S = 2;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [S-1:0]   ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n;
  logic [S*W-1:0] a_pin_i, a_pin_drv, b_pin_i, b_pin_drv;
  logic [S*W-1:0] a_pin_o, b_pin_o;
  logic [S-1:0]   a_pin_oe, b_pin_oe, conflict_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bus_latch_xcvr #(.SECTIONS(S), .WIDTH(W)) u0 (
    .clk(clk), .rst(rst),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_pin_i(a_pin_i), .a_pin_drv(a_pin_drv),
    .b_pin_i(b_pin_i), .b_pin_drv(b_pin_drv),
    .a_pin_o(a_pin_o), .a_pin_oe(a_pin_oe),
    .b_pin_o(b_pin_o), .b_pin_oe(b_pin_oe),
    .conflict_o(conflict_o)
  );

  // ctl = {ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n}, section 0 only
  typedef struct packed {
    logic [5:0] ctl;
    logic [7:0] a;
    logic       ad;
    logic [7:0] b;
    logic       bd;
    logic       eb_oe;
    logic [7:0] eb;
    logic       ea_oe;
    logic [7:0] ea;
    logic       ecf;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{6'b000111, 8'hA5, 1'b1, 8'h00, 1'b0, 1'b1, 8'hA5, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 open latch
    '{6'b000111, 8'h3C, 1'b1, 8'h00, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 follows source
    '{6'b010111, 8'h77, 1'b1, 8'h00, 1'b0, 1'b1, 8'h77, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 latch-enable rise
    '{6'b010111, 8'h11, 1'b1, 8'h00, 1'b0, 1'b1, 8'h77, 1'b0, 8'h00, 1'b0, 4'd5},  // R5 hold
    '{6'b000111, 8'h22, 1'b0, 8'h00, 1'b0, 1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 4'd8},  // R8 keeper on A
    '{6'b001111, 8'h9C, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd1},  // R1 output enable off
    '{6'b101111, 8'h4E, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd4},  // R4 direction-enable rise
    '{6'b110111, 8'hF0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd1},  // R1 direction off
    '{6'b010111, 8'h0F, 1'b1, 8'h00, 1'b0, 1'b1, 8'h4E, 1'b0, 8'h00, 1'b0, 4'd6},  // R6 hidden load shown
    '{6'b010000, 8'h0F, 1'b1, 8'hC3, 1'b1, 1'b1, 8'h4E, 1'b1, 8'hC3, 1'b1, 4'd9},  // R9 both driving
    '{6'b011010, 8'h0F, 1'b1, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b1, 8'h5A, 1'b0, 4'd7},  // R7 B-to-A capture
    '{6'b011011, 8'h0F, 1'b1, 8'h66, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd1},  // R1 all off
    '{6'b010000, 8'h0F, 1'b1, 8'h99, 1'b0, 1'b1, 8'h4E, 1'b1, 8'h66, 1'b1, 4'd8}   // R8 keeper on B
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    ab_en_n = '1; ab_le_n = '1; ab_oe_n = '1;
    ba_en_n = '1; ba_le_n = '1; ba_oe_n = '1;
    a_pin_i = '0; a_pin_drv = '0; b_pin_i = '0; b_pin_drv = '0;
  endtask

  initial begin
    idle_all();
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    // R10 reset state: nothing driven anywhere
    check("R10 reset oe/conflict", {2'b00, a_pin_oe, b_pin_oe, conflict_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ab_en_n[0], ab_le_n[0], ab_oe_n[0], ba_en_n[0], ba_le_n[0], ba_oe_n[0]} = VEC[i].ctl;
      a_pin_i[7:0] = VEC[i].a;  a_pin_drv[7:0] = {8{VEC[i].ad}};
      b_pin_i[7:0] = VEC[i].b;  b_pin_drv[7:0] = {8{VEC[i].bd}};
      @(posedge clk); #1;
      n_vec++;
      if (b_pin_oe[0] !== VEC[i].eb_oe || a_pin_oe[0] !== VEC[i].ea_oe ||
          conflict_o[0] !== VEC[i].ecf || (VEC[i].eb_oe && b_pin_o[7:0] !== VEC[i].eb) ||
          (VEC[i].ea_oe && a_pin_o[7:0] !== VEC[i].ea) || a_pin_oe[1] || b_pin_oe[1]) begin
        n_bad++;
        $display("FAIL vec %0d R%0d actual boe=%b b=%02h aoe=%b a=%02h cf=%b expected boe=%b b=%02h aoe=%b a=%02h cf=%b",
                 i, VEC[i].req, b_pin_oe[0], b_pin_o[7:0], a_pin_oe[0], a_pin_o[7:0], conflict_o[0],
                 VEC[i].eb_oe, VEC[i].eb, VEC[i].ea_oe, VEC[i].ea, VEC[i].ecf);
      end
    end

    // R7 section independence: section 1 open while section 0 holds 4E
    @(negedge clk);
    ab_en_n[1] = 1'b0; ab_le_n[1] = 1'b0; ab_oe_n[1] = 1'b0;
    a_pin_i[15:8] = 8'hE1; a_pin_drv[15:8] = '1;
    ba_oe_n[0] = 1'b1;
    @(posedge clk); #1;
    check("R7 section1 data", b_pin_o[15:8], 8'hE1);
    check("R7 section0 untouched", b_pin_o[7:0], 8'h4E);
    check("R7 section1 drive", {7'd0, b_pin_oe[1]}, 8'h01);

    // R10 reset mid-run clears latches and keepers
    @(negedge clk);
    idle_all();
    rst = 1'b1;
    ab_en_n[0] = 1'b0; ab_oe_n[0] = 1'b0;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check("R10 latch cleared", b_pin_o[7:0], 8'h00);
    check("R10 hold after reset drives", {7'd0, b_pin_oe[0]}, 8'h01);
    @(negedge clk) ab_le_n[0] = 1'b0;
    @(posedge clk); #1;
    check("R10 keeper cleared", b_pin_o[7:0], 8'h00);

    // R3 capture while shown: open, then close with new data in the same cycle
    @(negedge clk) a_pin_i[7:0] = 8'hB2; a_pin_drv[7:0] = '1;
    @(posedge clk);
    @(negedge clk) ab_le_n[0] = 1'b1; a_pin_i[7:0] = 8'h6D;
    @(posedge clk);
    @(negedge clk) a_pin_i[7:0] = 8'h01;
    @(posedge clk); #1;
    check("R3 edge-cycle data kept", b_pin_o[7:0], 8'h6D);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule